// File: doc/BRIEF.md
# Trunked Radio Codeword Checksum Codec

A serial error-check unit for 64-bit radio codewords. Each codeword holds 48 message bits followed by a 16-bit check field. The unit handles one bit for each cycle in which its bit enable is high. A start strobe opens a new word and fixes the direction for that word.

In generate mode the unit takes the 48 message bits and divides them modulo 2 by a degree-15 generator. It inverts the last remainder bit and adds an even parity bit. It then presents the resulting 16-bit check word both in parallel and as a serial stream. The serial stream is the tail of the codeword and can be appended directly to the message.

In check mode the unit takes all 64 received bits. It reports a 15-bit syndrome, a parity-error flag and a pass flag. These results stay valid until the next start. In both modes a one-cycle done pulse marks the end of the word.

Top module: `tcw_codec`

## Requirements
- R1: In generate mode, check bits 1 to 15 are the remainder of M(x)·x^15 divided modulo 2 by x^15+x^14+x^13+x^11+x^4+x^2+1. M(x) is the 48 message bits, with the first bit received as the highest power. The x^14 coefficient comes first, and the last (x^0) remainder bit is inverted. An all-zero message therefore gives the check word 16'h0003.
- R2: Check bit 16 makes the 48 message bits plus the 15 altered remainder bits plus itself have even parity.
- R3: One cycle after the 48th message bit, `result` holds the check word, with `result[15]` as the first bit on the line and `result[0]` as the parity bit. `bit_out_valid` then rises. On each of the next 16 enabled cycles, `bit_out` presents the next check bit and then advances. `bit_out_valid` is only ever high in generate mode.
- R4: In check mode, received bit 63 is inverted before division, and bits 1 to 63 are divided as in R1. Syndrome bit S(k) is placed at `result[k-1]`, where S1 is the x^14 coefficient of the remainder.
- R5: In check mode, `result[15]` is 1 exactly when the even parity of received bits 1 to 63 differs from received bit 64.
- R6: In check mode, `pass` is 1 exactly when all 16 bits of `result` are zero. A correctly generated codeword therefore passes.
- R7: After reset, and one cycle after a start strobe, `result`, `pass`, `done` and `bit_out_valid` are 0, and the divider and parity are cleared. `mode` (0 = generate, 1 = check) is sampled at start. A start during a word abandons that word.
- R8: `done` is high for exactly one cycle. In check mode it follows the 64th accepted bit; in generate mode it follows the 16th check-bit advance.
- R9: After `done`, `result` and `pass` hold, and enabled bits are ignored, until the next start.
- R10: Cycles with `bit_en` low change nothing, whatever the value on `bit_in`.
- R11: Codeword bit 1 is handled first. When a word is formed from bytes, each byte goes most significant bit first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Clear and begin a new word |
| mode | input | 1 | 0 generate, 1 check; sampled at start |
| bit_en | input | 1 | Bit enable, one codeword bit per high cycle |
| bit_in | input | 1 | Serial message or received bit |
| bit_out | output | 1 | Serial check bit (generate mode) |
| bit_out_valid | output | 1 | High while check bits are being presented |
| result | output | 16 | Check word (generate) or syndrome with parity error at bit 15 (check) |
| pass | output | 1 | Received word passed both tests |
| done | output | 1 | One-cycle end-of-word pulse |

## Verification
Generate mode is tried with these messages:
- an all-zero message, which exposes whether the last-bit inversion and the parity bit are applied;
- all-ones and alternating patterns;
- random byte-built messages, fed with gaps in which the bit enable is low and the idle data toggles.

Check mode is tried with these words:
- clean codewords, which must give a zero syndrome;
- single-bit errors in the message, in the remainder field, at the inverted bit 63 and at the parity bit, which separate divider errors from parity errors;
- double errors, which leave parity intact but not the syndrome.

A word abandoned by a new start, and enabled bits sent after completion, show whether state leaks from one word into the next.

// File: rtl/tcw_pkg.sv
package tcw_pkg;
    localparam int unsigned REM_W    = 15;
    localparam logic [REM_W-1:0] GEN_POLY = 15'h6815;
    localparam int unsigned MSG_BITS = 48;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RUN,
        PH_LOAD,
        PH_SEND,
        PH_HOLD
    } phase_e;
endpackage

// File: rtl/tcw_divider.sv
// Serial modulo-2 divider: remainder of the input stream times x^W.
module tcw_divider #(
    parameter int unsigned W = 15,
    parameter logic [W-1:0] POLY = 15'h6815
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         step,
    input  logic         din,
    output logic [W-1:0] rem
);
    typedef struct packed {
        logic [W-1:0] rem;
    } div_s;

    div_s div_d, div_q;
    logic fb;

    always_comb begin
        div_d = div_q;
        fb    = din ^ div_q.rem[W-1];
        if (clr) begin
            div_d.rem = '0;
        end else if (step) begin
            div_d.rem = {div_q.rem[W-2:0], 1'b0} ^ (fb ? POLY : '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    assign rem = div_q.rem;

    // R7: a clear leaves an empty remainder
    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (rem == '0));

    // R10: no step, no change
    a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !step) |=> $stable(rem));
endmodule

// File: rtl/tcw_seq.sv
// Word sequencer: phase, bit counter, mode latch and done pulse.
module tcw_seq
    import tcw_pkg::*;
#(
    parameter int unsigned WORD_BITS = 64,
    parameter int unsigned MSG_BITS  = 48,
    parameter int unsigned CHK_BITS  = 16,
    localparam int unsigned CW = $clog2(WORD_BITS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          mode,
    input  logic          bit_en,
    output phase_e        phase,
    output logic [CW-1:0] cnt,
    output logic          chk,
    output logic          done
);
    typedef struct packed {
        phase_e        phase;
        logic [CW-1:0] cnt;
        logic          chk;
        logic          done;
    } seq_s;

    seq_s seq_d, seq_q;

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        if (start) begin
            seq_d.phase = PH_RUN;
            seq_d.cnt   = '0;
            seq_d.chk   = mode;
        end else begin
            case (seq_q.phase)
                PH_RUN: if (bit_en) begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                    if (seq_q.chk && seq_q.cnt == CW'(WORD_BITS - 1)) begin
                        seq_d.phase = PH_HOLD;
                        seq_d.done  = 1'b1;
                    end else if (!seq_q.chk && seq_q.cnt == CW'(MSG_BITS - 1)) begin
                        seq_d.phase = PH_LOAD;
                    end
                end
                PH_LOAD: begin
                    seq_d.phase = PH_SEND;
                    seq_d.cnt   = '0;
                end
                PH_SEND: if (bit_en) begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                    if (seq_q.cnt == CW'(CHK_BITS - 1)) begin
                        seq_d.phase = PH_HOLD;
                        seq_d.done  = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q       <= '0;
            seq_q.phase <= PH_IDLE;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign phase = seq_q.phase;
    assign cnt   = seq_q.cnt;
    assign chk   = seq_q.chk;
    assign done  = seq_q.done;

    // R8: done never lasts two cycles
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: start always opens a fresh word
    a_r7_start_run: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (phase == PH_RUN && cnt == '0));
endmodule

// File: rtl/tcw_codec.sv
// Codeword check-field generator and checker, one bit per enable.
module tcw_codec
    import tcw_pkg::*;
#(
    parameter int unsigned REM_W    = tcw_pkg::REM_W,
    parameter logic [REM_W-1:0] POLY = tcw_pkg::GEN_POLY,
    parameter int unsigned MSG_BITS = tcw_pkg::MSG_BITS,
    localparam int unsigned CHK_BITS  = REM_W + 1,
    localparam int unsigned WORD_BITS = MSG_BITS + CHK_BITS,
    localparam int unsigned CW        = $clog2(WORD_BITS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                mode,
    input  logic                bit_en,
    input  logic                bit_in,
    output logic                bit_out,
    output logic                bit_out_valid,
    output logic [CHK_BITS-1:0] result,
    output logic                pass,
    output logic                done
);
    typedef struct packed {
        logic                par;
        logic [CHK_BITS-1:0] sh;
        logic [CHK_BITS-1:0] word;
        logic                pass;
    } top_s;

    top_s          top_d, top_q;
    phase_e        phase;
    logic [CW-1:0] cnt;
    logic          chk;
    logic [REM_W-1:0] rem;
    logic          take, at_parity, at_flip, div_step, div_din;
    logic [REM_W-1:0] cw_v;

    tcw_seq #(
        .WORD_BITS (WORD_BITS),
        .MSG_BITS  (MSG_BITS),
        .CHK_BITS  (CHK_BITS)
    ) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .mode   (mode),
        .bit_en (bit_en),
        .phase  (phase),
        .cnt    (cnt),
        .chk    (chk),
        .done   (done)
    );

    assign take      = (phase == PH_RUN) && bit_en && !start;
    assign at_parity = (cnt == CW'(WORD_BITS - 1));
    assign at_flip   = chk && (cnt == CW'(WORD_BITS - 2));
    assign div_step  = take && !at_parity;
    assign div_din   = bit_in ^ at_flip;

    tcw_divider #(
        .W    (REM_W),
        .POLY (POLY)
    ) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (start),
        .step  (div_step),
        .din   (div_din),
        .rem   (rem)
    );

    always_comb begin
        top_d = top_q;
        cw_v  = {rem[REM_W-1:1], ~rem[0]};
        if (start) begin
            top_d = '0;
        end else begin
            if (take && !at_parity) top_d.par = top_q.par ^ bit_in;
            case (phase)
                PH_LOAD: begin
                    top_d.sh   = {cw_v, top_q.par ^ (^cw_v)};
                    top_d.word = {cw_v, top_q.par ^ (^cw_v)};
                end
                PH_SEND: if (bit_en) begin
                    top_d.sh = {top_q.sh[CHK_BITS-2:0], 1'b0};
                end
                PH_RUN: if (take && chk && at_parity) begin
                    for (int k = 0; k < REM_W; k++) begin
                        top_d.word[k] = rem[REM_W-1-k];
                    end
                    top_d.word[CHK_BITS-1] = top_q.par ^ bit_in;
                    top_d.pass = (rem == '0) && (top_q.par == bit_in);
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    assign bit_out       = top_q.sh[CHK_BITS-1];
    assign bit_out_valid = (phase == PH_SEND);
    assign result        = top_q.word;
    assign pass          = top_q.pass;

    // R9: results frozen after completion until a new start
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_HOLD && !start) |=> ($stable(result) && $stable(pass)));

    // R6: a pass never coexists with a nonzero syndrome
    a_r6_pass_zero: assert property (@(posedge clk) disable iff (!rst_n)
        pass |-> (result == '0));

    // R3: serial check bits only in generate mode
    a_r3_out_gen_only: assert property (@(posedge clk) disable iff (!rst_n)
        bit_out_valid |-> !chk);
endmodule

// File: tb/test_tcw_codec.sv
module test_tcw_codec;
    logic clk = 1'b0;
    logic rst_n, start, mode, bit_en, bit_in;
    logic bit_out, bit_out_valid, pass, done;
    logic [15:0] result;
    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    tcw_codec i_tcw_codec (
        .clk (clk), .rst_n (rst_n), .start (start), .mode (mode),
        .bit_en (bit_en), .bit_in (bit_in), .bit_out (bit_out),
        .bit_out_valid (bit_out_valid), .result (result),
        .pass (pass), .done (done)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // long division by the full generator, textbook form
    function automatic logic [14:0] ref_div(input logic [63:0] bits, input int n);
        logic [15:0] acc = '0;
        for (int i = n - 1; i >= 0; i--) begin
            acc = {acc[14:0], bits[i]};
            if (acc[15]) acc ^= 16'hE815;
        end
        for (int i = 0; i < 15; i++) begin
            acc = {acc[14:0], 1'b0};
            if (acc[15]) acc ^= 16'hE815;
        end
        return acc[14:0];
    endfunction

    function automatic logic [15:0] ref_gen(input logic [47:0] m);
        logic [14:0] r;
        r = ref_div({16'b0, m}, 48);
        r[0] = ~r[0];
        return {r, (^m) ^ (^r)};
    endfunction

    function automatic logic [15:0] ref_chk(input logic [63:0] w);
        logic [62:0] d;
        logic [14:0] r;
        logic [15:0] s;
        d = w[63:1];
        d[0] = ~d[0];
        r = ref_div({1'b0, d}, 63);
        for (int k = 0; k < 15; k++) s[k] = r[14-k];
        s[15] = (^w[63:1]) ^ w[0];
        return s;
    endfunction

    task automatic put_bit(input logic b, input int gap);
        for (int g = 0; g < gap; g++) begin
            bit_en = 1'b0; bit_in = ~b;
            @(negedge clk);
        end
        bit_en = 1'b1; bit_in = b;
        @(negedge clk);
        bit_en = 1'b0;
    endtask

    task automatic do_start(input logic m);
        bit_en = 1'b0; start = 1'b1; mode = m;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run_gen(input logic [47:0] m, input int gap, input string tag);
        logic [15:0] exp;
        int early;
        exp = ref_gen(m);
        early = 0;
        do_start(1'b0);
        for (int i = 47; i >= 0; i--) begin
            if (done) early++;
            put_bit(m[i], gap);
        end
        @(negedge clk);
        check({tag, " R1 R2 check word"}, result, exp);
        check({tag, " R3 out valid"}, bit_out_valid, 1'b1);
        for (int k = 15; k >= 0; k--) begin
            if (bit_out !== exp[k] || done) early++;
            put_bit(1'b0, gap);
        end
        check({tag, " R3 serial bits"}, early, 0);
        check({tag, " R8 done after send"}, done, 1'b1);
        @(negedge clk);
        check({tag, " R8 done single"}, done, 1'b0);
    endtask

    task automatic run_chk(input logic [63:0] w, input int gap, input string tag);
        logic [15:0] exp;
        int early;
        exp = ref_chk(w);
        early = 0;
        do_start(1'b1);
        for (int k = 63; k >= 0; k--) begin
            if (done || bit_out_valid) early++;
            put_bit(w[k], gap);
        end
        check({tag, " R8 no early done"}, early, 0);
        check({tag, " R8 done"}, done, 1'b1);
        check({tag, " R4 R5 syndrome"}, result, exp);
        check({tag, " R6 pass"}, pass, (exp == 16'h0));
        @(negedge clk);
        check({tag, " R8 done single"}, done, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog R8 actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [47:0] m;
        logic [63:0] w;
        logic [15:0] held;
        rst_n = 1'b0; start = 1'b0; mode = 1'b0; bit_en = 1'b0; bit_in = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R7 reset result", result, 16'h0);
        check("R7 reset flags", {pass, done, bit_out_valid}, 3'b000);

        // R1 R2: all-zero message gives 0003
        run_gen(48'h0, 0, "gen zero");
        check("R1 R2 zero literal", ref_gen(48'h0), 16'h0003);
        run_gen({48{1'b1}}, 0, "gen ones");
        run_gen(48'hAAAA_AAAA_AAAA, 1, "gen alt");
        for (int t = 0; t < 4; t++) begin
            m = {$urandom(), $urandom()};
            run_gen(m, t % 3, "R10 gen rand gaps");
        end

        // R6 R11: clean byte-built codewords pass
        for (int t = 0; t < 4; t++) begin
            m = {$urandom(), $urandom()};
            w = {m, ref_gen(m)};
            run_chk(w, t % 2, "R11 clean");
            check("R6 clean pass", {pass, result}, 17'h1_0000);
        end

        // R4 R5: single-bit error injection
        m = 48'h1234_5678_9ABC;
        w = {m, ref_gen(m)};
        for (int p = 1; p <= 63; p += 31) begin
            run_chk(w ^ (64'h1 << (64 - p)), 0, "R4 single err");
            check("R5 parity flag single", result[15], 1'b1);
        end
        run_chk(w ^ 64'h2, 0, "R4 err bit63");
        check("R5 parity flag bit63", result[15], 1'b1);
        run_chk(w ^ (64'h1 << 10), 0, "R4 err remainder");
        run_chk(w ^ 64'h1, 0, "R5 err bit64");
        check("R5 bit64 only parity", result, 16'h8000);
        run_chk(w ^ (64'h3 << 40), 1, "R4 double err");
        check("R5 double parity ok", result[15], 1'b0);
        check("R6 double fails", pass, 1'b0);

        // R9: extra bits after done are ignored
        held = result;
        for (int k = 0; k < 5; k++) put_bit(k[0], 0);
        check("R9 result held", result, held);
        check("R9 no done", done, 1'b0);

        // R7: abandoned word leaves no trace
        do_start(1'b0);
        for (int k = 0; k < 20; k++) put_bit(1'b1, 0);
        check("R7 cleared on start", result, 16'h0);
        m = 48'hC0FF_EE00_1357;
        run_chk({m, ref_gen(m)}, 0, "R7 after abort");
        check("R7 abort then pass", pass, 1'b1);
        do_start(1'b1);
        check("R7 start clears", {pass, done, result}, 18'h0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule